// File: doc/BRIEF.md
# Streaming CRC-16 Residue Checker

This block runs a reflected CCITT-polynomial CRC-16 over a byte stream that arrives one byte per cycle with a valid strobe and an end-of-frame flag. The running remainder restarts from all ones on the first byte of every frame. The end-of-frame flag is what marks a frame boundary.

In generate mode the block emits the two CRC bytes of the finished frame on its output stream in the two cycles after the final byte, low byte first. In check mode the sender's message and its appended CRC pass through the same engine. At the final byte the complemented remainder is compared with a fixed, nonzero residue. Because that residue does not depend on the message, the receiver gets a pass or fail pulse without ever locating where the message stops and the CRC begins.

Top module: `crc16_stream`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `frame_ok` and `frame_err` are all low.
- R2: The CRC uses polynomial x^16+x^12+x^5+1, processed LSB first (reflected constant 0x8408), with initial value 0xFFFF and final XOR 0xFFFF. The message 01 02 03 04 05 06 07 08 yields bytes D4 6D, and DE AD BE EF yields CB E5.
- R3: In generate mode, the cycle after the final byte is accepted has `out_valid` high with the CRC low byte and `out_last` low. The following cycle carries the high byte with `out_last` high.
- R4: In check mode, `frame_ok` pulses for exactly one cycle, the cycle after the final byte, when the frame including its appended CRC leaves the byte sequence 47 0F, which is complemented register value 0x0F47.
- R5: In check mode, any other final value pulses `frame_err` for one cycle instead. For example, a corrupted byte or a CRC appended in swapped order both fail. `frame_ok` and `frame_err` are never high together.
- R6: The remainder is reseeded to 0xFFFF after every end-of-frame flag, so consecutive frames are independent.
- R7: Cycles with `in_valid` low change nothing, so idle gaps inside a frame leave the result unchanged.
- R8: Check mode never drives `out_valid`. Generate mode never drives `frame_ok` or `frame_err`. The mode is sampled with the final byte of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_check | input | 1 | 1 = check frame against residue, 0 = generate CRC |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the frame |
| out_valid | output | 1 | CRC byte valid (generate mode) |
| out_data | output | 8 | CRC byte, low byte first |
| out_last | output | 1 | Second CRC byte |
| frame_ok | output | 1 | One-cycle pass pulse (check mode) |
| frame_err | output | 1 | One-cycle fail pulse (check mode) |

## Verification
The bench builds the block with its default parameters: the reflected 0x8408 polynomial, all-ones seed, all-ones output XOR and residue 0x0F47. With these values the two fixed message vectors and the 47 0F residue are directly checkable. The parameters also let random messages be framed by an independently written bit-serial model, then checked as both good and corrupted frames. Idle gaps, back-to-back frames and one-byte frames exercise the reseeding at frame boundaries.

// File: rtl/crc16_stream.sv
module crc16_stream #(
  parameter logic [15:0] POLY_REV = 16'h8408,
  parameter logic [15:0] SEED     = 16'hFFFF,
  parameter logic [15:0] XOROUT   = 16'hFFFF,
  parameter logic [15:0] RESIDUE  = 16'h0F47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_check,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       frame_ok,
  output logic       frame_err
);

  function automatic logic [15:0] byte_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ POLY_REV) : (r >> 1);
    return r;
  endfunction

  logic [15:0] rem, hold;
  logic        fresh;
  logic [1:0]  left;

  wire [15:0] seed_now = fresh ? SEED : rem;
  wire [15:0] rem_next = byte_step(seed_now, in_data);
  wire [15:0] fin      = rem_next ^ XOROUT;
  wire        at_end   = in_valid & in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= SEED;
      fresh     <= 1'b1;
      hold      <= '0;
      left      <= '0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      if (in_valid) begin
        rem   <= rem_next;
        fresh <= in_last;
      end
      frame_ok  <= at_end & mode_check & (fin == RESIDUE);
      frame_err <= at_end & mode_check & (fin != RESIDUE);
      if (at_end && !mode_check) begin
        hold <= fin;
        left <= 2'd2;
      end else if (left != 2'd0) begin
        left <= left - 2'd1;
      end
    end
  end

  assign out_valid = (left != 2'd0);
  assign out_last  = (left == 2'd1);
  assign out_data  = (left == 2'd2) ? hold[7:0] : hold[15:8];

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));
  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || frame_err) |-> $past(at_end && mode_check));
  a_r3_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !mode_check) |=> (out_valid && !out_last));
  a_r3_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last && !(at_end && !mode_check)) |=> (out_valid && out_last));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!frame_ok && !frame_err));

endmodule

// File: tb/crc16_stream_bench.sv
module crc16_stream_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_check = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_last, frame_ok, frame_err;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  crc16_stream u_crc16_stream (
    .clk(clk), .rst_n(rst_n), .mode_check(mode_check), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .frame_ok(frame_ok), .frame_err(frame_err)
  );

  int checks = 0, fails = 0;
  logic [8:0] q_out[$];
  string      q_out_tag[$];
  bit         q_chk[$];
  string      q_chk_tag[$];
  bit         done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] m[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (m[k])
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ m[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c ^ 16'hFFFF;
  endfunction

  task automatic send(input logic [7:0] m[$], input bit chk, input int gap, input string tag, input bit exp_ok);
    foreach (m[k]) begin
      @(negedge clk);
      mode_check = chk;
      in_valid = 1'b1;
      in_data = m[k];
      in_last = (k == m.size() - 1);
      if (in_last) begin
        if (chk) begin
          q_chk.push_back(exp_ok);
          q_chk_tag.push_back(tag);
        end else begin
          logic [15:0] c;
          c = ref_crc(m);
          q_out.push_back({1'b0, c[7:0]});
          q_out_tag.push_back(tag);
          q_out.push_back({1'b1, c[15:8]});
          q_out_tag.push_back(tag);
        end
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 8'hA5;
        in_last = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (out_valid) begin
      if (q_out.size() == 0) check(1'b0, "R8 unexpected out_valid", {23'd0, out_last, out_data}, 0);
      else begin
        logic [8:0] e;
        string t;
        e = q_out.pop_front();
        t = q_out_tag.pop_front();
        check({out_last, out_data} == e, t, {23'd0, out_last, out_data}, {23'd0, e});
      end
    end
    if (frame_ok || frame_err) begin
      check(!(frame_ok && frame_err), "R5 both flags", {30'd0, frame_ok, frame_err}, 32'd2);
      if (q_chk.size() == 0) check(1'b0, "R8 unexpected verdict", {30'd0, frame_ok, frame_err}, 0);
      else begin
        bit e;
        string t;
        e = q_chk.pop_front();
        t = q_chk_tag.pop_front();
        check(frame_ok == e && frame_err == !e, t, {30'd0, frame_ok, frame_err}, {30'd0, e, !e});
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] m[$];
    logic [15:0] c;
    repeat (3) @(negedge clk);
    check(!out_valid && !frame_ok && !frame_err, "R1 in reset",
          {29'd0, out_valid, frame_ok, frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !frame_ok && !frame_err, "R1 after reset",
          {29'd0, out_valid, frame_ok, frame_err}, 0);

    m = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    check(ref_crc(m) == 16'h6DD4, "R2 vector D4 6D", {16'd0, ref_crc(m)}, 32'h6DD4);
    send(m, 0, 0, "R2 R3 gen 01..08", 0);
    idle(3);
    m = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    check(ref_crc(m) == 16'hE5CB, "R2 vector CB E5", {16'd0, ref_crc(m)}, 32'hE5CB);
    send(m, 0, 0, "R2 R3 gen DEADBEEF", 0);
    idle(3);

    m = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'hD4, 8'h6D};
    send(m, 1, 0, "R4 check 01..08", 1);
    m = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hCB, 8'hE5};
    send(m, 1, 0, "R4 R6 check DEADBEEF back-to-back", 1);
    m = '{8'hDE, 8'hAD, 8'hBF, 8'hEF, 8'hCB, 8'hE5};
    send(m, 1, 0, "R5 corrupted byte", 0);
    m = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hE5, 8'hCB};
    send(m, 1, 0, "R5 swapped CRC order", 0);
    m = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'hD4, 8'h6D};
    send(m, 1, 2, "R7 check with idle gaps", 1);
    idle(2);

    for (int f = 0; f < 40; f++) begin
      int n;
      bit chk;
      n = 1 + ($urandom % 12);
      chk = f[0];
      m = {};
      for (int k = 0; k < n; k++) m.push_back(8'($urandom));
      if (chk) begin
        bit bad;
        c = ref_crc(m);
        m.push_back(c[7:0]);
        m.push_back(c[15:8]);
        bad = (f % 6 == 1);
        if (bad) m[$urandom % m.size()] ^= 8'h10;
        send(m, 1, f % 3, bad ? "R5 random corrupt" : "R4 R6 random good", !bad);
      end else begin
        send(m, 0, f % 3, "R3 R6 R7 random gen", 0);
        idle(2);
      end
    end

    m = '{8'h5A};
    send(m, 0, 0, "R6 one-byte gen", 0);
    idle(2);
    send(m, 0, 0, "R6 one-byte gen repeat", 0);
    idle(2);

    idle(6);
    check(q_out.size() == 0, "R3 all CRC bytes emitted", q_out.size(), 0);
    check(q_chk.size() == 0, "R4 all verdicts seen", q_chk.size(), 0);
    check(!out_valid && !frame_ok && !frame_err, "R7 quiet when idle",
          {29'd0, out_valid, frame_ok, frame_err}, 0);
    done = 1;
    summary();
  end
endmodule